// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs one serial management transaction toward an Ethernet PHY for each command word a host hands it. The host writes a single 32-bit word that holds everything the frame needs: the start code, the operation, the PHY address, the register address, the turnaround code and, for a write, the data. The engine then shifts a clause-22 frame out on MDC and MDIO, led by a preamble of ones. For a read it releases MDIO for the turnaround and data bits and gathers the returned value into the low half of the same word.

Software polls a ready flag instead of waiting for a completion pulse. The flag is high while the engine can take a command. It drops on the clock edge that accepts one and rises again when the last MDC cycle ends. The MDC rate comes from the host clock through one of two division ratios, chosen per transaction. A management enable input gates the whole engine: while it is low, commands are refused, and dropping it during a frame abandons that frame.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is 0.
- R2: A `cmd_wr` pulse with `idle` and `mgmt_en` both high stores `cmd_wdata` into the command word. `idle` reads 0 from the clock edge that samples the pulse.
- R3: A `cmd_wr` pulse while a frame is in progress, or while `mgmt_en` is low, changes neither the command word nor the frame on the wire. With `mgmt_en` low, no MDC edge is produced.
- R4: The `div_sel` value sampled with the command fixes the MDC period for the whole frame: 0 gives 32 host clocks and 1 gives 48 host clocks. MDC is high for the first half of each period and sits at 0 while idle.
- R5: Each frame is 32 ones followed by command bits 31 down to 0, most significant first. MDIO changes only when MDC falls, so each bit is stable across its MDC rising edge.
- R6: When command bits 29:28 are 10 (read), `mdio_oe` is 0 for the last 18 bit times (the turnaround and the 16 data bits). MDIO is sampled in the cycle before each of the last 16 MDC rising edges. The first sample becomes bit 15. At completion these 16 bits replace `cmd_rdata[15:0]`, and bits 31:16 are kept.
- R7: For any other value of bits 29:28 (01 is write), `mdio_oe` is 1 for all 64 bit times and the command word is left unchanged.
- R8: `idle` returns to 1 exactly 64 MDC periods after the accepting edge, and `mdio_oe` is 0 whenever `idle` is 1.
- R9: If `mgmt_en` falls during a frame, `idle` is 1 and `mdio_oe` is 0 from the next clock edge, and the command word keeps the value written (no partial read data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 1 | MDC ratio select: 0 = /32, 1 = /48 |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Current command word, low half holding read data after a read |
| idle | output | 1 | 1 when the engine can accept a command |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = high impedance) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench sweeps PHY and register addresses, read data patterns and both ratios. It captures every bit at the MDC rising edges and compares the whole 64-bit frame and its enable pattern against values built from the command word. A design that is off by one at the preamble-to-command boundary, or that releases MDIO one bit early or late, shows a shifted frame or shifted enable mask. A read that samples on the wrong MDC edge returns a rotated value.

A command written mid-frame, together with a ratio change in the same window, targets designs that reload the word or the divider while busy: they would show a corrupted frame or the wrong frame length. Dropping the enable in the middle of a read targets designs that keep driving the line or that commit partial read data into the word.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int CMD_W  = 32;
  localparam int DATA_W = 16;
  localparam int OP_HI  = 29;
  localparam int OP_LO  = 28;

  typedef enum logic [1:0] {
    OPC_NONE  = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10,
    OPC_RSVD  = 2'b11
  } mdio_op_e;

  function automatic logic word_is_read(input logic [CMD_W-1:0] w);
    return mdio_op_e'(w[OP_HI:OP_LO]) == OPC_READ;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_A = 32,
  parameter int DIV_B = 48,
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sel,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] half;

  always_comb begin
    lim  = sel ? CNT_W'(DIV_B - 1) : CNT_W'(DIV_A - 1);
    half = sel ? CNT_W'(DIV_B / 2 - 1) : CNT_W'(DIV_A / 2 - 1);
    rise_tick = run && (cnt == half);
    fall_tick = run && (cnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick)
        mdc <= 1'b1;
      else if (fall_tick)
        mdc <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int IDX_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [CMD_W-1:0]  start_word,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              last_bit,
  output logic              rd_active,
  output logic [DATA_W-1:0] rd_data
);

  localparam int FRAME_LEN  = PRE_LEN + CMD_W;
  localparam int LAST       = FRAME_LEN - 1;
  localparam int TA_FIRST   = FRAME_LEN - DATA_W - 2;
  localparam int DATA_FIRST = FRAME_LEN - DATA_W;

  logic [FRAME_LEN-1:0] out_sh;
  logic [IDX_W-1:0]     bit_idx;
  logic [IDX_W-1:0]     next_idx;

  assign next_idx = bit_idx + 1'b1;
  assign last_bit = (bit_idx == IDX_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sh    <= '0;
      bit_idx   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
      rd_active <= 1'b0;
      rd_data   <= '0;
    end else if (start) begin
      out_sh    <= {{PRE_LEN{1'b1}}, start_word};
      bit_idx   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b1;
      rd_active <= word_is_read(start_word);
      rd_data   <= '0;
    end else if (stop) begin
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
    end else begin
      if (rise_tick && rd_active && (bit_idx >= IDX_W'(DATA_FIRST)))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        bit_idx <= next_idx;
        out_sh  <= {out_sh[FRAME_LEN-2:0], 1'b0};
        mdio_o  <= out_sh[FRAME_LEN-2];
        mdio_oe <= !(rd_active && (next_idx >= IDX_W'(TA_FIRST)));
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 48,
  parameter int PRE_LEN  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mgmt_en,
  input  logic             div_sel,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  output logic             idle,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DIV_MAX   = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CNT_W     = $clog2(DIV_MAX);

  logic [CMD_W-1:0]  cmd_reg;
  logic              idle_q;
  logic              div_q;
  logic              rise_tick, fall_tick, last_bit, rd_active;
  logic [DATA_W-1:0] rd_data;
  logic              accept, abort, done;

  assign accept = cmd_wr && idle_q && mgmt_en;
  assign abort  = !idle_q && !mgmt_en;
  assign done   = !idle_q && fall_tick && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_reg <= '0;
      idle_q  <= 1'b1;
      div_q   <= 1'b0;
    end else if (accept) begin
      cmd_reg <= cmd_wdata;
      idle_q  <= 1'b0;
      div_q   <= div_sel;
    end else if (abort) begin
      idle_q  <= 1'b1;
    end else if (done) begin
      idle_q  <= 1'b1;
      if (rd_active)
        cmd_reg[DATA_W-1:0] <= rd_data;
    end
  end

  assign cmd_rdata = cmd_reg;
  assign idle      = idle_q;

  mdio_mdc_gen #(
    .DIV_A (DIV_FAST),
    .DIV_B (DIV_SLOW),
    .CNT_W (CNT_W)
  ) u_mdc_gen (
    .clk       (clk),
    .rst       (rst),
    .run       (!idle_q),
    .sel       (div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN),
    .IDX_W   (IDX_W)
  ) u_frame_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .stop       (abort || done),
    .start_word (cmd_wdata),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .last_bit   (last_bit),
    .rd_active  (rd_active),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/mdio_mgmt_engine_sva.sv
module mdio_mgmt_engine_sva (
  input logic        clk,
  input logic        rst,
  input logic        mgmt_en,
  input logic        cmd_wr,
  input logic [31:0] cmd_rdata,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  assert_accept_clears_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && idle && mgmt_en) |=> !idle);

  assert_busy_keeps_word_R3: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(cmd_rdata[31:16]));

  assert_disabled_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !mgmt_en) |=> $stable(cmd_rdata));

  assert_mdc_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && $past(idle)) |-> !mdc);

  assert_mdio_moves_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(!idle) && !$stable(mdio_o)) |-> $fell(mdc));

  assert_idle_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mdio_oe);

  assert_abort_releases_R9: assert property (@(posedge clk) disable iff (rst)
    (!idle && !mgmt_en) |=> (idle && !mdio_oe));

endmodule

bind mdio_mgmt_engine mdio_mgmt_engine_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .mgmt_en   (mgmt_en),
  .cmd_wr    (cmd_wr),
  .cmd_rdata (cmd_rdata),
  .idle      (idle),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_engine_bench.sv
`timescale 1ns/100ps
module mdio_mgmt_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mgmt_en = 1'b1;
  logic        div_sel = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int t_r0 = 0, t_r1 = 0, t_f0 = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_resp = '0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc = cyc + 1;

  mdio_mgmt_engine u_mdio_mgmt_engine (
    .clk(clk), .rst(rst), .mgmt_en(mgmt_en), .div_sel(div_sel),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY side: capture each bit at MDC rise, answer read data after MDC fall
  always @(posedge mdc) begin
    if (rise_cnt == 0) t_r0 = cyc;
    if (rise_cnt == 1) t_r1 = cyc;
    if (rise_cnt < 64) begin
      cap_o[63-rise_cnt]  = mdio_o;
      cap_oe[63-rise_cnt] = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    if (rise_cnt == 1) t_f0 = cyc;
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_resp[63-rise_cnt];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic start_cmd(input logic [31:0] w, input logic sel);
    @(negedge clk);
    div_sel = sel; cmd_wdata = w; cmd_wr = 1'b1; rise_cnt = 0;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] w, input logic sel,
                           input logic [15:0] resp, input logic poke);
    int cycles;
    int n;
    logic rd;
    n = sel ? 48 : 32;
    rd = (w[29:28] == 2'b10);
    phy_resp = resp;
    start_cmd(w, sel);
    chk("R2 idle low after accept", {63'd0, idle}, 64'd0);
    cycles = 0;
    while (!idle && cycles < 10000) begin
      if (poke && cycles == 100) begin
        cmd_wr = 1'b1; cmd_wdata = ~w; div_sel = ~sel;
      end
      if (poke && cycles == 101) cmd_wr = 1'b0;
      @(negedge clk);
      cycles++;
    end
    chk(poke ? "R3 R8 frame length with busy write" : "R8 frame length",
        64'(cycles), 64'(64 * n));
    chk("R4 rising edge count", 64'(rise_cnt), 64'd64);
    chk("R4 MDC period", 64'(t_r1 - t_r0), 64'(n));
    chk("R4 MDC high time", 64'(t_f0 - t_r0), 64'(n / 2));
    chk(poke ? "R3 R5 frame bits with busy write" : "R5 frame bits",
        cap_o & cap_oe, {32'hFFFF_FFFF, w} & (rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF));
    if (rd) begin
      chk("R6 read enable pattern", cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
      chk(poke ? "R3 R6 read data with busy write" : "R6 read data",
          64'(cmd_rdata), 64'({w[31:16], resp}));
    end else begin
      chk("R7 write enable pattern", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R7 word kept", 64'(cmd_rdata), 64'(w));
    end
    chk("R8 idle no drive", {63'd0, mdio_oe}, 64'd0);
  endtask

  initial begin
    #(190000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle", {63'd0, idle}, 64'd1);
    chk("R1 mdc", {63'd0, mdc}, 64'd0);
    chk("R1 oe", {63'd0, mdio_oe}, 64'd0);
    chk("R1 word", 64'(cmd_rdata), 64'd0);

    for (int i = 0; i < 10; i++)
      run_frame(mkword(2'b10, 5'(i * 3 + 1), 5'(31 - i * 3), 16'h0),
                i[0], 16'hA5C3 ^ 16'(i * 16'h1111), 1'b0);
    for (int i = 0; i < 4; i++)
      run_frame(mkword(2'b01, 5'(31 - i), 5'(i * 7), 16'(i * 16'h3C0F + 16'h8001)),
                i[0], 16'h0, 1'b0);
    run_frame({2'b01, 2'b11, 5'd9, 5'd17, 2'b10, 16'h1234}, 1'b0, 16'h0, 1'b0);
    run_frame(mkword(2'b10, 5'd5, 5'd1, 16'h0), 1'b0, 16'h7E81, 1'b1);

    // R3: write with enable low is refused
    w = cmd_rdata;
    mgmt_en = 1'b0;
    start_cmd(32'h6F0F_1234, 1'b0);
    repeat (200) @(negedge clk);
    chk("R3 disabled idle", {63'd0, idle}, 64'd1);
    chk("R3 disabled no mdc", 64'(rise_cnt), 64'd0);
    chk("R3 disabled word", 64'(cmd_rdata), 64'(w));
    mgmt_en = 1'b1;

    // R9: enable drops mid read
    w = mkword(2'b10, 5'd3, 5'd2, 16'hBEEF);
    phy_resp = 16'h0123;
    start_cmd(w, 1'b0);
    repeat (1700) @(negedge clk);
    mgmt_en = 1'b0;
    @(negedge clk);
    chk("R9 abort idle", {63'd0, idle}, 64'd1);
    chk("R9 abort oe", {63'd0, mdio_oe}, 64'd0);
    chk("R9 abort word", 64'(cmd_rdata), 64'(w));
    @(negedge clk);
    chk("R9 abort mdc", {63'd0, mdc}, 64'd0);
    mgmt_en = 1'b1;
    run_frame(mkword(2'b10, 5'd31, 5'd0, 16'h0), 1'b1, 16'hFFFE, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule